// File: doc/BRIEF.md
# Automatic RTS/CTS Handshake Controller

This block performs hardware handshaking for a UART. On the receive side it compares the receive FIFO fill level with two programmable thresholds. When the FIFO fills past the upper threshold, it raises the active-low request-to-send line so the remote transmitter pauses. It lowers that line again only after the FIFO has drained below the lower threshold. The gap between the two thresholds stops the line from toggling on every byte.

On the transmit side it synchronises the active-low clear-to-send input and produces a permit signal. The transmitter samples that permit before it starts each character, so a character already on the wire always completes.

Both directions raise a one-cycle interrupt pulse when their line goes from low to high. The FIFO, the shift registers and the register decode sit outside this block. They supply the fill level, the thresholds, the enable bits and the software RTS bit.

Top module: `rts_cts_flow_ctl`

## Requirements
- R1: While automatic RTS is active (enable set and software RTS bit set), the cycle after the FIFO level is sampled strictly above the upper threshold, `rts_n` is 1.
- R2: While automatic RTS is active and the hold is set, the cycle after the level is sampled strictly below the lower threshold, `rts_n` returns to 0. A level between the thresholds, inclusive of both, keeps the previous state.
- R3: Automatic RTS changes nothing unless both the enable and the software RTS bit are 1. With the enable set and the software bit clear, `rts_n` stays 1 whatever the level.
- R4: `rts_irq` pulses for exactly one cycle, in the same cycle that the automatic hold drives `rts_n` from 0 to 1.
- R5: `cts_irq` pulses for one cycle when the synchronised `cts_n_in` goes from 0 to 1 while automatic CTS is enabled. It never pulses while automatic CTS is disabled.
- R6: `tx_may_start` is 1 when automatic CTS is disabled. When automatic CTS is enabled, `tx_may_start` is the inverse of the synchronised `cts_n_in`.
- R7: `cts_n_in` passes through a two-flop synchronizer, so a change on the input reaches `tx_may_start` and `cts_irq` exactly two rising clock edges after it is applied.
- R8: When the two thresholds are equal, the block behaves as a single-threshold controller: it holds above the value, releases below it, and keeps its state at the value.
- R9: With the enable clear, `rts_n` equals the inverse of the software RTS bit and the hold state is cleared. After the enable is set again, a level between the thresholds leaves `rts_n` at 0.
- R10: In reset, `rts_n` is the inverse of `sw_rts`, both interrupts are 0, and the synchronised CTS value is 1, so `tx_may_start` is 0 if automatic CTS is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| thr_hi | input | LVL_W | Upper threshold; hold when level exceeds it |
| thr_lo | input | LVL_W | Lower threshold; release when level is below it |
| auto_rts_en | input | 1 | Enable automatic RTS |
| auto_cts_en | input | 1 | Enable automatic CTS |
| sw_rts | input | 1 | Software RTS bit (1 = assert RTS) |
| cts_n_in | input | 1 | Asynchronous active-low clear-to-send from the remote end |
| rts_n | output | 1 | Active-low request-to-send |
| tx_may_start | output | 1 | Transmitter may start its next character |
| rts_irq | output | 1 | One-cycle pulse on an automatic RTS rise |
| cts_irq | output | 1 | One-cycle pulse on a synchronised CTS rise |

## Verification
The embedded properties check on every cycle that:
- a held receive side keeps `rts_n` high;
- a level below the lower threshold releases the hold;
- an inactive enable clears the hold;
- every hold rise comes with `rts_irq`;
- a CTS interrupt is a single pulse that coincides with a withdrawn permit.

Some behaviours only the bench scenarios can show:
- the exact two-edge latency of the synchronizer;
- that the hysteresis band holds its state on both the rising and the falling ramp;
- the single-threshold behaviour with equal thresholds;
- the software-bit and enable combinations, checked against an arithmetic model over all threshold settings swept.

// File: rtl/fc_pkg.sv
// Package: shared types for the RTS/CTS handshake controller.
// Assumes: nothing; only type definitions.
package fc_pkg;
    typedef enum logic {
        RX_FLOWING = 1'b0,
        RX_HELD    = 1'b1
    } rx_flow_e;
endpackage

// File: rtl/fc_sync.sv
// Module: fc_sync
// Multi-stage synchronizer for one asynchronous bit, reset to RST_VAL.
// Assumes: STAGES >= 1; the input is a level, not a pulse to be caught.
module fc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Purpose: single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_many
            // Purpose: shift the input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fc_rts_ctrl.sv
// Module: fc_rts_ctrl
// Receive-side hysteresis: holds rts_n high once the level is above thr_hi,
// releases it once the level is below thr_lo, and pulses rts_irq when the hold sets.
// Assumes: thr_lo <= thr_hi; equal values give single-threshold behaviour.
module fc_rts_ctrl
    import fc_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    input  logic             auto_en,
    input  logic             sw_rts,
    output logic             rts_n,
    output logic             rts_irq
);
    rx_flow_e state;
    logic     active;
    logic     above;
    logic     below;

    // Purpose: decode whether automatic control acts and where the level sits.
    always_comb begin
        active = auto_en && sw_rts;
        above  = rx_level > thr_hi;
        below  = rx_level < thr_lo;
    end

    // Purpose: hysteresis state and the interrupt pulse on entering the hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_FLOWING;
            rts_irq <= 1'b0;
        end else if (!active) begin
            state   <= RX_FLOWING;
            rts_irq <= 1'b0;
        end else if (above) begin
            state   <= RX_HELD;
            rts_irq <= (state == RX_FLOWING);
        end else if (below) begin
            state   <= RX_FLOWING;
            rts_irq <= 1'b0;
        end else begin
            rts_irq <= 1'b0;
        end
    end

    // Purpose: the output follows the software bit, forced high while held.
    always_comb begin
        rts_n = !sw_rts || (auto_en && (state == RX_HELD));
    end

    assert_hold_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && state == RX_HELD) |-> rts_n);

    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && state == RX_HELD && $past(rx_level) < $past(thr_lo)
         && !($past(rx_level) > $past(thr_hi))) |=> state == RX_FLOWING);

    assert_inactive_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> state == RX_FLOWING);

    assert_irq_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == RX_HELD) |-> rts_irq);

    assert_irq_only_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rts_irq |-> (state == RX_HELD));
endmodule

// File: rtl/fc_cts_ctrl.sv
// Module: fc_cts_ctrl
// Transmit-side gate: produces the start permit from the synchronised CTS
// and pulses cts_irq on its rising edge while automatic CTS is enabled.
// Assumes: cts_s is already synchronous to clk.
module fc_cts_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_s,
    input  logic auto_en,
    output logic tx_may_start,
    output logic cts_irq
);
    logic cts_prev;

    // Purpose: remember the previous synchronised CTS for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cts_prev <= 1'b1;
        else        cts_prev <= cts_s;
    end

    // Purpose: permit and rising-edge interrupt.
    always_comb begin
        tx_may_start = !auto_en || !cts_s;
        cts_irq      = auto_en && cts_s && !cts_prev;
    end

    assert_irq_blocks_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cts_irq |-> !tx_may_start);

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cts_irq |=> !cts_irq);
endmodule

// File: rtl/rts_cts_flow_ctl.sv
// Module: rts_cts_flow_ctl (top)
// Automatic RTS/CTS handshake: RTS hysteresis on the receive FIFO level,
// a synchronised CTS gate for the transmitter, and edge interrupts for both.
// Assumes: the transmitter samples tx_may_start only between characters.
module rts_cts_flow_ctl #(
    parameter int LVL_W     = 6,
    parameter int CTS_SYNCS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             sw_rts,
    input  logic             cts_n_in,
    output logic             rts_n,
    output logic             tx_may_start,
    output logic             rts_irq,
    output logic             cts_irq
);
    logic cts_s;

    fc_sync #(.STAGES(CTS_SYNCS), .RST_VAL(1'b1)) i_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cts_n_in),
        .q     (cts_s)
    );

    fc_rts_ctrl #(.LVL_W(LVL_W)) i_rts (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_level (rx_level),
        .thr_hi   (thr_hi),
        .thr_lo   (thr_lo),
        .auto_en  (auto_rts_en),
        .sw_rts   (sw_rts),
        .rts_n    (rts_n),
        .rts_irq  (rts_irq)
    );

    fc_cts_ctrl i_cts (
        .clk          (clk),
        .rst_n        (rst_n),
        .cts_s        (cts_s),
        .auto_en      (auto_cts_en),
        .tx_may_start (tx_may_start),
        .cts_irq      (cts_irq)
    );
endmodule

// File: tb/test_rts_cts_flow_ctl.sv
module test_rts_cts_flow_ctl;
    localparam int LVL_W = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [LVL_W-1:0] rx_level, thr_hi, thr_lo;
    logic             auto_rts_en, auto_cts_en, sw_rts, cts_n_in;
    logic             rts_n, tx_may_start, rts_irq, cts_irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;
    bit  hold_m   = 0;
    bit  irq_m    = 0;

    always #2 clk = ~clk;

    rts_cts_flow_ctl #(.LVL_W(LVL_W)) i_rts_cts_flow_ctl (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thr_hi(thr_hi),
        .thr_lo(thr_lo), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .sw_rts(sw_rts), .cts_n_in(cts_n_in), .rts_n(rts_n),
        .tx_may_start(tx_may_start), .rts_irq(rts_irq), .cts_irq(cts_irq)
    );

    task automatic chk(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Apply a level, advance one edge, update the model and compare.
    task automatic apply(int lvl, string tag);
        bit act;
        rx_level = lvl[LVL_W-1:0];
        act = auto_rts_en && sw_rts;
        tick();
        irq_m = 0;
        if (!act) hold_m = 0;
        else if (lvl > int'(thr_hi)) begin irq_m = !hold_m; hold_m = 1; end
        else if (lvl < int'(thr_lo)) hold_m = 0;
        chk(tag, rts_n, !sw_rts || (auto_rts_en && hold_m));
        chk("R4", rts_irq, irq_m);
    endtask

    initial begin
        rst_n = 0; rx_level = 0; thr_hi = 20; thr_lo = 10;
        auto_rts_en = 0; auto_cts_en = 0; sw_rts = 0; cts_n_in = 1;
        repeat (3) tick();
        // R10: reset values
        chk("R10", rts_n, 1'b1);
        chk("R10", rts_irq, 1'b0);
        chk("R10", cts_irq, 1'b0);
        chk("R10", tx_may_start, 1'b1);
        auto_cts_en = 1;
        #1 chk("R10", tx_may_start, 1'b0);
        auto_cts_en = 0;
        rst_n = 1;
        tick();

        // Sweep: all enable/software combinations, several thresholds,
        // separated (R1/R2) and equal (R8) thresholds, full ramps up and down.
        for (int combo = 0; combo < 4; combo++) begin
            auto_rts_en = combo[1];
            sw_rts      = combo[0];
            for (int hi = 4; hi <= 28; hi += 8) begin
                for (int eq = 0; eq < 2; eq++) begin
                    thr_hi = hi[LVL_W-1:0];
                    thr_lo = eq ? hi[LVL_W-1:0] : LVL_W'(hi - 3);
                    for (int l = 0; l <= 32; l++)
                        apply(l, !(combo == 3) ? "R3" : (eq ? "R8" : "R1"));
                    for (int l = 32; l >= 0; l--)
                        apply(l, !(combo == 3) ? "R3" : (eq ? "R8" : "R2"));
                end
            end
        end

        // R9: clearing the enable releases the hold; re-enabling starts flowing.
        auto_rts_en = 1; sw_rts = 1; thr_hi = 20; thr_lo = 10;
        apply(32, "R1");
        auto_rts_en = 0;
        #1 chk("R9", rts_n, 1'b0);
        apply(32, "R9");
        auto_rts_en = 1;
        apply(15, "R9");
        apply(32, "R9");
        apply(5, "R2");

        // R5/R6: automatic CTS off, the permit stays set and no interrupt.
        cts_n_in = 0; tick(); tick();
        cts_n_in = 1; tick(); tick();
        chk("R6", tx_may_start, 1'b1);
        chk("R5", cts_irq, 1'b0);
        tick();
        auto_cts_en = 1;
        #1 chk("R6", tx_may_start, 1'b0);
        cts_n_in = 0;
        tick();
        chk("R7", tx_may_start, 1'b0);
        tick();
        chk("R7", tx_may_start, 1'b1);
        cts_n_in = 1;
        tick();
        chk("R7", tx_may_start, 1'b1);
        chk("R7", cts_irq, 1'b0);
        tick();
        chk("R6", tx_may_start, 1'b0);
        chk("R5", cts_irq, 1'b1);
        tick();
        chk("R5", cts_irq, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule